// File: doc/BRIEF.md
# Caption Line Strobe Generator

This block sits behind a sync separator and picks out the single video line that carries caption data. It counts line pulses from the start of each field, remembers whether the field is odd or even, and raises a strobe for the whole of the caption line. The strobe falls at the line pulse that ends that line. In the cycle after that pulse a one-cycle capture enable tells the data slicer that the caption word is complete. A downstream reader samples the field flag on the falling edge of the strobe to learn which field the word came from.

A 2-bit mode input selects the line and the fields that get the strobe. It also selects the line reference. Three modes take the separated hsync pulse as the line reference. The fourth mode divides a free-running oscillator enable by a parameter (32 by default) to form a local line rate. In that mode the field-flag pin is given over to the oscillator, so the flag is not driven. The line counter and the field flag are single registers. The strobe is decoded from them, and only the capture enable adds a register stage.

Top module: `caption_line_strobe`

## Requirements
- R1: Reset is synchronous and active high. While in reset and afterwards, `line_strobe`, `capture_en` and `field_flag` are 0. Until the first `field_start`, the line count holds at its maximum, so hsync pulses alone never produce a strobe.
- R2: A `field_start` pulse sets the line count to 1. Each later line pulse adds one. A `field_start` and a line pulse in the same cycle count as a field start only.
- R3: The line count saturates at 511 (2^LINE_W-1) and never wraps. A field longer than 511 lines therefore produces no second strobe.
- R4: For `mode` 2'b00 and 2'b01, the strobe is issued on line 21 only when the field was even, meaning `field_odd`=0 at `field_start`.
- R5: For `mode` 2'b10, the strobe is issued on line 21 of both odd and even fields.
- R6: For `mode` 2'b11, the strobe is issued on line 22 of both odd and even fields.
- R7: `field_flag_oe` is 1 in modes 2'b00, 2'b10 and 2'b11 and 0 in mode 2'b01. When it is 1, `field_flag` shows the parity latched at `field_start` (1 for odd, 0 for even). When it is 0, `field_flag` is 0.
- R8: The strobe is high for exactly one line period. It rises in the cycle after the line pulse that starts the caption line and falls in the cycle after the next line pulse. `capture_en` is high for one cycle, the first cycle in which the strobe is low again.
- R9: In mode 2'b01 the line reference is the oscillator enable and `hsync_pulse` is ignored. In every other mode `hsync_pulse` is the line reference and `osc_en` is ignored.
- R10: In mode 2'b01 a line pulse occurs on every 32nd cycle (DIV) that has `osc_en` high, counted from the last `field_start` or from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Operating mode: 00, 01, 10 or 11 |
| hsync_pulse | input | 1 | One-cycle pulse for each separated hsync |
| field_start | input | 1 | One-cycle pulse at the start of a field |
| field_odd | input | 1 | Field parity, sampled at `field_start` (1 = odd) |
| osc_en | input | 1 | Oscillator-rate enable, used in mode 01 |
| line_strobe | output | 1 | High for the whole caption line |
| field_flag | output | 1 | Latched field parity (1 = odd) |
| field_flag_oe | output | 1 | Field flag is driven |
| capture_en | output | 1 | One-cycle pulse when the caption line has ended |

## Verification
The field flag and its enable settle one clock after the `field_start` edge. The strobe changes one clock after the line pulse that moves the counter onto or off the caption line. The capture enable appears one clock after the line pulse that ends the strobe. In mode 01, that line pulse is the 32nd oscillator-enable cycle. The bench drives every input on the falling clock edge and holds it for exactly one rising edge. It samples the outputs on the next falling edge, which is the first point where each result is due. It records, for each line step, the step at which the strobe and the capture enable were seen, so a result that is one line early or late is caught.

// File: rtl/cap_strobe_pkg.sv
package cap_strobe_pkg;

   typedef enum logic [1:0] {
      MODE_VCR_HS  = 2'b00,
      MODE_VCR_OSC = 2'b01,
      MODE_TV_L21  = 2'b10,
      MODE_TV_L22  = 2'b11
   } cap_mode_e;

endpackage

// File: rtl/cap_line_ref.sv
module cap_line_ref
   import cap_strobe_pkg::*;
#(
   parameter int DIV = 32
) (
   input  logic      clk,
   input  logic      rst,
   input  cap_mode_e mode,
   input  logic      hsync_pulse,
   input  logic      osc_en,
   input  logic      field_start,
   output logic      line_pulse
);
   localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [DW-1:0] LAST = DW'(DIV - 1);
   localparam bit POW2 = ((DIV & (DIV - 1)) == 0);

   logic          use_osc;
   logic [DW-1:0] div_q;
   logic [DW-1:0] div_inc;

   assign use_osc = (mode == MODE_VCR_OSC);

   generate
      if (POW2) begin : g_wrap
         assign div_inc = div_q + 1'b1;
      end else begin : g_cmp
         assign div_inc = (div_q == LAST) ? '0 : div_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || field_start || !use_osc) begin
         div_q <= '0;
      end else if (osc_en) begin
         div_q <= div_inc;
      end
   end

   assign line_pulse = use_osc ? (osc_en && (div_q == LAST)) : hsync_pulse;

endmodule

// File: rtl/cap_line_count.sv
module cap_line_count #(
   parameter int LINE_W = 9
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              field_start,
   input  logic              line_pulse,
   output logic [LINE_W-1:0] line_no
);
   localparam logic [LINE_W-1:0] LMAX = '1;
   localparam logic [LINE_W-1:0] FIRST = LINE_W'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         line_no <= LMAX;
      end else if (field_start) begin
         line_no <= FIRST;
      end else if (line_pulse && (line_no != LMAX)) begin
         line_no <= line_no + 1'b1;
      end
   end

endmodule

// File: rtl/cap_field_track.sv
module cap_field_track
   import cap_strobe_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  cap_mode_e mode,
   input  logic      field_start,
   input  logic      field_odd,
   output logic      odd_q,
   output logic      flag,
   output logic      flag_oe
);
   always_ff @(posedge clk) begin
      if (rst) begin
         odd_q <= 1'b0;
      end else if (field_start) begin
         odd_q <= field_odd;
      end
   end

   assign flag_oe = (mode != MODE_VCR_OSC);
   assign flag    = flag_oe & odd_q;

endmodule

// File: rtl/cap_strobe_gen.sv
module cap_strobe_gen
   import cap_strobe_pkg::*;
#(
   parameter int LINE_W = 9,
   parameter int LINE_A = 21,
   parameter int LINE_B = 22
) (
   input  logic              clk,
   input  logic              rst,
   input  cap_mode_e         mode,
   input  logic [LINE_W-1:0] line_no,
   input  logic              odd_q,
   input  logic              line_pulse,
   input  logic              field_start,
   output logic              strobe,
   output logic              capture_en
);
   localparam logic [LINE_W-1:0] TGT_A = LINE_W'(LINE_A);
   localparam logic [LINE_W-1:0] TGT_B = LINE_W'(LINE_B);

   logic [LINE_W-1:0] target;
   logic              field_ok;

   assign target   = (mode == MODE_TV_L22) ? TGT_B : TGT_A;
   assign field_ok = (mode == MODE_TV_L21) || (mode == MODE_TV_L22) || !odd_q;
   assign strobe   = field_ok && (line_no == target);

   always_ff @(posedge clk) begin
      if (rst) begin
         capture_en <= 1'b0;
      end else begin
         capture_en <= strobe && line_pulse && !field_start;
      end
   end

endmodule

// File: rtl/caption_line_strobe.sv
module caption_line_strobe
   import cap_strobe_pkg::*;
#(
   parameter int LINE_W = 9,
   parameter int DIV    = 32,
   parameter int LINE_A = 21,
   parameter int LINE_B = 22
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [1:0] mode,
   input  logic       hsync_pulse,
   input  logic       field_start,
   input  logic       field_odd,
   input  logic       osc_en,
   output logic       line_strobe,
   output logic       field_flag,
   output logic       field_flag_oe,
   output logic       capture_en
);
   generate
      if (LINE_W < 5 || LINE_W > 16) begin : g_bad_w
         $error("LINE_W out of range");
      end
      if (DIV < 2) begin : g_bad_div
         $error("DIV must be at least 2");
      end
      if (LINE_A < 2 || LINE_B < 2 || LINE_A >= (2 ** LINE_W) - 1 ||
          LINE_B >= (2 ** LINE_W) - 1) begin : g_bad_line
         $error("caption lines must lie inside the counter range");
      end
   endgenerate

   cap_mode_e         mode_e;
   logic              line_pulse;
   logic [LINE_W-1:0] line_no;
   logic              odd_q;

   assign mode_e = cap_mode_e'(mode);

   cap_line_ref #(.DIV(DIV)) i_ref (
      .clk         (clk),
      .rst         (rst),
      .mode        (mode_e),
      .hsync_pulse (hsync_pulse),
      .osc_en      (osc_en),
      .field_start (field_start),
      .line_pulse  (line_pulse)
   );

   cap_line_count #(.LINE_W(LINE_W)) i_cnt (
      .clk         (clk),
      .rst         (rst),
      .field_start (field_start),
      .line_pulse  (line_pulse),
      .line_no     (line_no)
   );

   cap_field_track i_fld (
      .clk         (clk),
      .rst         (rst),
      .mode        (mode_e),
      .field_start (field_start),
      .field_odd   (field_odd),
      .odd_q       (odd_q),
      .flag        (field_flag),
      .flag_oe     (field_flag_oe)
   );

   cap_strobe_gen #(.LINE_W(LINE_W), .LINE_A(LINE_A), .LINE_B(LINE_B)) i_gen (
      .clk         (clk),
      .rst         (rst),
      .mode        (mode_e),
      .line_no     (line_no),
      .odd_q       (odd_q),
      .line_pulse  (line_pulse),
      .field_start (field_start),
      .strobe      (line_strobe),
      .capture_en  (capture_en)
   );

endmodule

// File: rtl/cap_line_strobe_chk.sv
module cap_line_strobe_chk #(
   parameter int LINE_W = 9,
   parameter int LINE_A = 21,
   parameter int LINE_B = 22
) (
   input logic              clk,
   input logic              rst,
   input logic [1:0]        mode,
   input logic              osc_en,
   input logic              field_start,
   input logic              line_pulse,
   input logic [LINE_W-1:0] line_no,
   input logic              odd_q,
   input logic              line_strobe,
   input logic              field_flag_oe,
   input logic              capture_en
);
   localparam logic [LINE_W-1:0] LMAX = '1;

   // R2
   field_start_to_one_chk: assert property (@(posedge clk) disable iff (rst)
      field_start |=> (line_no == LINE_W'(1)));

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      (line_no == LMAX && !field_start) |=> (line_no == LMAX));

   // R4
   even_only_chk: assert property (@(posedge clk) disable iff (rst)
      (line_strobe && !mode[1]) |-> !odd_q);

   // R6
   line_b_chk: assert property (@(posedge clk) disable iff (rst)
      (line_strobe && mode == 2'b11) |-> (line_no == LINE_W'(LINE_B)));

   // R5
   line_a_chk: assert property (@(posedge clk) disable iff (rst)
      (line_strobe && mode != 2'b11) |-> (line_no == LINE_W'(LINE_A)));

   // R7
   flag_released_chk: assert property (@(posedge clk) disable iff (rst)
      (mode == 2'b01) |-> !field_flag_oe);

   // R8
   capture_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      capture_en |-> ($past(line_strobe) && !line_strobe));

   // R9
   osc_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (mode == 2'b01 && !osc_en && !field_start) |=> $stable(line_no));

   // R10
   osc_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      (mode == 2'b01 && line_pulse) |-> osc_en);

endmodule

bind caption_line_strobe cap_line_strobe_chk #(
   .LINE_W(LINE_W), .LINE_A(LINE_A), .LINE_B(LINE_B)
) i_chk (
   .clk           (clk),
   .rst           (rst),
   .mode          (mode),
   .osc_en        (osc_en),
   .field_start   (field_start),
   .line_pulse    (line_pulse),
   .line_no       (line_no),
   .odd_q         (odd_q),
   .line_strobe   (line_strobe),
   .field_flag_oe (field_flag_oe),
   .capture_en    (capture_en)
);

// File: tb/test_caption_line_strobe.sv
module test_caption_line_strobe;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] mode = 2'b00;
   logic       hsync_pulse = 1'b0;
   logic       field_start = 1'b0;
   logic       field_odd = 1'b0;
   logic       osc_en = 1'b0;
   logic       line_strobe, field_flag, field_flag_oe, capture_en;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   caption_line_strobe i_caption_line_strobe (
      .clk           (clk),
      .rst           (rst),
      .mode          (mode),
      .hsync_pulse   (hsync_pulse),
      .field_start   (field_start),
      .field_odd     (field_odd),
      .osc_en        (osc_en),
      .line_strobe   (line_strobe),
      .field_flag    (field_flag),
      .field_flag_oe (field_flag_oe),
      .capture_en    (capture_en)
   );

   typedef struct packed {
      logic [1:0] m;
      logic       odd;
      logic       oe;
      logic [7:0] line;
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{2'b00, 1'b0, 1'b1, 8'd21},
      '{2'b00, 1'b1, 1'b1, 8'd0},
      '{2'b01, 1'b0, 1'b0, 8'd21},
      '{2'b01, 1'b1, 1'b0, 8'd0},
      '{2'b10, 1'b1, 1'b1, 8'd21},
      '{2'b10, 1'b0, 1'b1, 8'd21},
      '{2'b11, 1'b1, 1'b1, 8'd22},
      '{2'b11, 1'b0, 1'b1, 8'd22}
   };

   int rise, highs, caps, capat;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic start_field(input logic odd, input logic with_hs);
      @(negedge clk);
      field_start = 1'b1;
      field_odd   = odd;
      hsync_pulse = with_hs;
      @(negedge clk);
      field_start = 1'b0;
      hsync_pulse = 1'b0;
   endtask

   // one line pulse through the mode's reference; samples right after it
   task automatic step(input int k);
      if (mode == 2'b01) begin
         @(negedge clk);
         osc_en = 1'b1;
         repeat (32) @(negedge clk);
         osc_en = 1'b0;
      end else begin
         @(negedge clk);
         hsync_pulse = 1'b1;
         @(negedge clk);
         hsync_pulse = 1'b0;
      end
      if (line_strobe) begin
         highs++;
         if (rise == 0) rise = k + 1;
      end
      if (capture_en) begin
         caps++;
         capat = k;
      end
   endtask

   task automatic run_lines(input int n);
      rise = 0; highs = 0; caps = 0; capat = 0;
      for (int k = 1; k <= n; k++) step(k);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(line_strobe == 1'b0, "R1 strobe in reset", line_strobe, 0);
      chk(capture_en == 1'b0, "R1 capture in reset", capture_en, 0);
      chk(field_flag == 1'b0, "R1 flag in reset", field_flag, 0);
      @(negedge clk);
      rst = 1'b0;
      // R1 no strobe before the first field start
      run_lines(30);
      chk(highs == 0, "R1 strobe before field start", highs, 0);
      chk(caps == 0, "R1 capture before field start", caps, 0);

      // vector table: R4 R5 R6 R7 R8 R10
      for (int v = 0; v < 8; v++) begin
         mode = VEC[v].m;
         start_field(VEC[v].odd, 1'b0);
         chk(field_flag_oe == VEC[v].oe, "R7 flag enable", field_flag_oe, VEC[v].oe);
         chk(field_flag == (VEC[v].oe & VEC[v].odd), "R7 flag value", field_flag,
             VEC[v].oe & VEC[v].odd);
         run_lines(30);
         chk(rise == int'(VEC[v].line), "R4/R5/R6 strobe line", rise, VEC[v].line);
         chk(highs == ((VEC[v].line != 0) ? 1 : 0), "R8 strobe one line", highs,
             (VEC[v].line != 0) ? 1 : 0);
         chk(caps == ((VEC[v].line != 0) ? 1 : 0), "R8 capture count", caps,
             (VEC[v].line != 0) ? 1 : 0);
         chk(capat == int'(VEC[v].line), "R8 capture position", capat, VEC[v].line);
      end

      // R3 saturation: no second strobe in a 540-line field
      mode = 2'b10;
      start_field(1'b1, 1'b0);
      run_lines(540);
      chk(rise == 21, "R3 first strobe", rise, 21);
      chk(highs == 1, "R3 no wrap strobe", highs, 1);

      // R2 field start wins over simultaneous hsync
      start_field(1'b0, 1'b1);
      run_lines(25);
      chk(rise == 21, "R2 field start priority", rise, 21);

      // R9 osc_en ignored outside mode 01
      start_field(1'b0, 1'b0);
      rise = 0; highs = 0; caps = 0; capat = 0;
      for (int k = 1; k <= 10; k++) step(k);
      @(negedge clk);
      osc_en = 1'b1;
      repeat (100) @(negedge clk);
      osc_en = 1'b0;
      for (int k = 11; k <= 30; k++) step(k);
      chk(rise == 21, "R9 osc ignored in hsync mode", rise, 21);

      // R9 hsync ignored in mode 01, R10 divider restarts at field start
      mode = 2'b01;
      start_field(1'b0, 1'b0);
      rise = 0; highs = 0; caps = 0; capat = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         hsync_pulse = 1'b1;
         @(negedge clk);
         hsync_pulse = 1'b0;
         if (line_strobe) highs++;
      end
      chk(highs == 0, "R9 hsync ignored in osc mode", highs, 0);
      run_lines(25);
      chk(rise == 21, "R10 osc divided line", rise, 21);
      chk(capat == 21, "R10 osc capture", capat, 21);

      // R1 reset clears state mid-strobe
      mode = 2'b10;
      start_field(1'b1, 1'b0);
      run_lines(20);
      chk(line_strobe == 1'b1, "R5 strobe before reset", line_strobe, 1);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk(line_strobe == 1'b0, "R1 strobe cleared", line_strobe, 0);
      chk(field_flag == 1'b0, "R1 flag cleared", field_flag, 0);
      rst = 1'b0;

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule